// File: doc/BRIEF.md
# Vertical Blanking Interval Gate

This block sits in the pixel path of a video encoder and decides, one line at a time, whether the content of a line inside the vertical blanking interval is forwarded or replaced by blanking levels. Each video standard has its own window of lines that may carry such data. The decision inside that window depends on several inputs: the VBI enable bit for the path in use (standard definition or high definition), the timing mode, a blank-control enable, and a copy-protection line exception. Lines outside the window always pass.

The line sequencer pulses `line_start` once at the start of every line and presents that line's number at the same time. The gate registers its decision on that pulse and holds it for the rest of the line. Incoming luma and chroma samples are then passed through or replaced by the blanking levels. In slave mode 0 the gate also raises a flag. This flag tells the code extractor to overwrite the blanking bit of the received timing reference codes, so that the VBI lines are carried.

Top module: `vbi_gate`

## Requirements
- R1: The window of lines that may carry VBI data, inclusive at both ends, is selected by `std_sel`: 0 = 525-line interlaced, lines 10..20; 1 = 625-line interlaced, lines 7..22; 2 = 525p, lines 13..42; 3 = 625p, lines 6..43.
- R2: A line outside the window of the selected standard always passes, whatever the enable, mode and control inputs.
- R3: For `std_sel` 0 and 1 the enable is `sd_vbi_en`; for 2 and 3 it is `hd_vbi_en`. When that enable is clear, every window line is blanked in every timing mode, except as stated in R6.
- R4: `timing_mode` encodes 0 = slave 0, 1 = slave 1/2, 2 or 3 = master. In slave 1/2 a window line passes only when the VBI enable and `blank_ctl_en` are both set. Otherwise the line is blanked, except as stated in R6.
- R5: `eav_override` is high for a line only if all three hold: slave 0, the VBI enable is set, and the line is inside the window. In every other case it is low.
- R6: When `cgms_en` is set, the copy-protection line passes even if the VBI enable is clear or the blank control is off. That line is 20 for 525-line interlaced, 22 for 625-line interlaced, 41 for 525p and 43 for 625p.
- R7: On a blanked line, `y_out` is 0x10 and `c_out` is 0x80. On a passed line, `y_out` and `c_out` equal `y_in` and `c_in`.
- R8: The decision is sampled on the clock edge where `line_start` is high. It takes effect from the next cycle and holds until the next `line_start`, whatever the other inputs do in between.
- R9: After reset `pass_line` is 1 and `eav_override` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_start | input | 1 | One-cycle pulse at the start of each line |
| line_num | input | 11 | Number of the line that is starting |
| std_sel | input | 2 | Video standard select |
| sd_vbi_en | input | 1 | VBI enable for the standard-definition path |
| hd_vbi_en | input | 1 | VBI enable for the progressive (HD) path |
| timing_mode | input | 2 | Timing mode select |
| blank_ctl_en | input | 1 | Blank-control enable used in slave 1/2 |
| cgms_en | input | 1 | Copy-protection line enable |
| y_in | input | 8 | Incoming luma sample |
| c_in | input | 8 | Incoming chroma sample |
| pass_line | output | 1 | Decision for the current line (1 = pass) |
| eav_override | output | 1 | Overwrite the blanking bit of received timing codes |
| y_out | output | 8 | Luma after gating |
| c_out | output | 8 | Chroma after gating |

## Verification
Assertions check the per-line decision rules on every line start: out-of-window lines pass, a disabled window line is blanked, slave 1/2 without blank control is blanked, and the copy-protection line survives. They also check that the decision stays stable between line starts and that the override appears only in slave 0. Some behaviour can only be shown by the bench's scenarios, because it rests on specific line numbers and sample values. This covers the exact window edges of each standard, the choice of the copy-protection line, and the blanking levels substituted into the samples.

// File: rtl/vbi_pkg.sv
package vbi_pkg;

  typedef enum logic [1:0] {
    STD_SD525 = 2'd0,
    STD_SD625 = 2'd1,
    STD_P525  = 2'd2,
    STD_P625  = 2'd3
  } vid_std_e;

  typedef enum logic [1:0] {
    MODE_SLAVE0  = 2'd0,
    MODE_SLAVE12 = 2'd1,
    MODE_MASTER  = 2'd2,
    MODE_MASTER2 = 2'd3
  } tmode_e;

  // First line of the VBI data window, per standard
  function automatic int unsigned win_first(input logic [1:0] s);
    case (s)
      2'd0:    return 10;
      2'd1:    return 7;
      2'd2:    return 13;
      default: return 6;
    endcase
  endfunction

  // Last line of the VBI data window, per standard
  function automatic int unsigned win_last(input logic [1:0] s);
    case (s)
      2'd0:    return 20;
      2'd1:    return 22;
      2'd2:    return 42;
      default: return 43;
    endcase
  endfunction

  // Line reserved for copy-protection content, per standard
  function automatic int unsigned cp_line(input logic [1:0] s);
    case (s)
      2'd0:    return 20;
      2'd1:    return 22;
      2'd2:    return 41;
      default: return 43;
    endcase
  endfunction

  // Progressive standards use the HD path enable
  function automatic logic uses_hd(input logic [1:0] s);
    return s[1];
  endfunction

endpackage

// File: rtl/vbi_window.sv
module vbi_window #(
  parameter int LINE_W = 11
) (
  input  logic [1:0]        std_sel,
  input  logic [LINE_W-1:0] line_num,
  output logic              in_win,
  output logic              on_cp
);
  logic [LINE_W-1:0] lo, hi, cpl;

  always_comb begin
    lo     = LINE_W'(vbi_pkg::win_first(std_sel));
    hi     = LINE_W'(vbi_pkg::win_last(std_sel));
    cpl    = LINE_W'(vbi_pkg::cp_line(std_sel));
    in_win = (line_num >= lo) && (line_num <= hi);
    on_cp  = (line_num == cpl);
  end
endmodule

// File: rtl/vbi_decide.sv
module vbi_decide (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_start,
  input  logic       in_win,
  input  logic       on_cp,
  input  logic [1:0] std_sel,
  input  logic       sd_vbi_en,
  input  logic       hd_vbi_en,
  input  logic [1:0] timing_mode,
  input  logic       blank_ctl_en,
  input  logic       cgms_en,
  output logic       pass_q,
  output logic       ovr_q
);
  import vbi_pkg::*;

  logic vbi_on, is_s0, is_s12, mode_ok, cp_keep, pass_next, ovr_next;

  always_comb begin
    vbi_on    = uses_hd(std_sel) ? hd_vbi_en : sd_vbi_en;
    is_s0     = (timing_mode == MODE_SLAVE0);
    is_s12    = (timing_mode == MODE_SLAVE12);
    mode_ok   = is_s12 ? blank_ctl_en : 1'b1;
    cp_keep   = cgms_en && on_cp;
    pass_next = !in_win || (vbi_on && mode_ok) || cp_keep;
    ovr_next  = is_s0 && vbi_on && in_win;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_q <= 1'b1;
      ovr_q  <= 1'b0;
    end else if (line_start) begin
      pass_q <= pass_next;
      ovr_q  <= ovr_next;
    end
  end

  // R2: lines outside the window always pass
  assert_outside_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !in_win) |=> pass_q);

  // R3: window line with VBI disabled and no copy-protection exception is blanked
  assert_disabled_blank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && in_win && !vbi_on && !cp_keep) |=> !pass_q);

  // R4: slave 1/2 without blank control blanks window lines
  assert_slave12_blank_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && in_win && is_s12 && !blank_ctl_en && !cp_keep) |=> !pass_q);

  // R5: override only ever raised in slave 0
  assert_override_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !is_s0) |=> !ovr_q);

  // R6: copy-protection line survives
  assert_cp_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && cgms_en && on_cp) |=> pass_q);

  // R8: decision held between line starts
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> ($stable(pass_q) && $stable(ovr_q)));
endmodule

// File: rtl/vbi_blank_mux.sv
module vbi_blank_mux #(
  parameter int          DATA_W  = 8,
  parameter logic [DATA_W-1:0] Y_BLANK = DATA_W'(8'h10),
  parameter logic [DATA_W-1:0] C_BLANK = DATA_W'(8'h80)
) (
  input  logic              pass,
  input  logic [DATA_W-1:0] y_in,
  input  logic [DATA_W-1:0] c_in,
  output logic [DATA_W-1:0] y_out,
  output logic [DATA_W-1:0] c_out
);
  always_comb begin
    y_out = pass ? y_in : Y_BLANK;
    c_out = pass ? c_in : C_BLANK;
  end
endmodule

// File: rtl/vbi_gate.sv
module vbi_gate #(
  parameter int LINE_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic [LINE_W-1:0] line_num,
  input  logic [1:0]        std_sel,
  input  logic              sd_vbi_en,
  input  logic              hd_vbi_en,
  input  logic [1:0]        timing_mode,
  input  logic              blank_ctl_en,
  input  logic              cgms_en,
  input  logic [DATA_W-1:0] y_in,
  input  logic [DATA_W-1:0] c_in,
  output logic              pass_line,
  output logic              eav_override,
  output logic [DATA_W-1:0] y_out,
  output logic [DATA_W-1:0] c_out
);
  logic in_win, on_cp;

  vbi_window #(.LINE_W(LINE_W)) u_win (
    .std_sel (std_sel),
    .line_num(line_num),
    .in_win  (in_win),
    .on_cp   (on_cp)
  );

  vbi_decide u_dec (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_start  (line_start),
    .in_win      (in_win),
    .on_cp       (on_cp),
    .std_sel     (std_sel),
    .sd_vbi_en   (sd_vbi_en),
    .hd_vbi_en   (hd_vbi_en),
    .timing_mode (timing_mode),
    .blank_ctl_en(blank_ctl_en),
    .cgms_en     (cgms_en),
    .pass_q      (pass_line),
    .ovr_q       (eav_override)
  );

  vbi_blank_mux #(.DATA_W(DATA_W)) u_mux (
    .pass (pass_line),
    .y_in (y_in),
    .c_in (c_in),
    .y_out(y_out),
    .c_out(c_out)
  );

  // R5: override implies the line is being passed
  assert_override_passes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eav_override |-> pass_line);
endmodule

// File: tb/vbi_gate_test.sv
module vbi_gate_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        line_start = 0;
  logic [10:0] line_num = '0;
  logic [1:0]  std_sel = '0;
  logic        sd_vbi_en = 0, hd_vbi_en = 0;
  logic [1:0]  timing_mode = 2'd2;
  logic        blank_ctl_en = 0, cgms_en = 0;
  logic [7:0]  y_in = 8'h5A, c_in = 8'h3C;
  logic        pass_line, eav_override;
  logic [7:0]  y_out, c_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vbi_gate uut (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_num(line_num),
    .std_sel(std_sel), .sd_vbi_en(sd_vbi_en), .hd_vbi_en(hd_vbi_en),
    .timing_mode(timing_mode), .blank_ctl_en(blank_ctl_en), .cgms_en(cgms_en),
    .y_in(y_in), .c_in(c_in), .pass_line(pass_line), .eav_override(eav_override),
    .y_out(y_out), .c_out(c_out)
  );

  // Vector: std(2) line(11) sd(1) hd(1) mode(2) bctl(1) cp(1) exp_pass(1) exp_ovr(1)
  localparam int NV = 20;
  localparam logic [20:0] VEC [NV] = '{
    {2'd0, 11'd10, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0}, // R1 lower edge 525i
    {2'd0, 11'd9,  1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0}, // R2 below window
    {2'd0, 11'd15, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 disabled blanks
    {2'd0, 11'd20, 1'b0, 1'b0, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0}, // R6 cp line 525i
    {2'd0, 11'd21, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0}, // R1 above window
    {2'd1, 11'd7,  1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0}, // R1 lower edge 625i
    {2'd1, 11'd22, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1}, // R5 slave0 override
    {2'd1, 11'd23, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0}, // R2 above window
    {2'd1, 11'd6,  1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0}, // R5 no ovr outside
    {2'd2, 11'd13, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 HD uses hd_en
    {2'd2, 11'd42, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 no blank ctl
    {2'd2, 11'd42, 1'b0, 1'b1, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0}, // R4 blank ctl on
    {2'd2, 11'd43, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0}, // R1 above 525p
    {2'd3, 11'd6,  1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1}, // R5 625p slave0
    {2'd3, 11'd43, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0}, // R6 cp line 625p
    {2'd3, 11'd5,  1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0}, // R2 below 625p
    {2'd3, 11'd43, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 upper edge blank
    {2'd2, 11'd41, 1'b0, 1'b0, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0}, // R6 cp line 525p
    {2'd1, 11'd22, 1'b0, 1'b0, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0}, // R6 cp line 625i
    {2'd0, 11'd12, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0}  // R4 SD slave1/2
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Start a line with the given settings; sample one cycle later
  task automatic run_line(input logic [1:0] s, input logic [10:0] ln, input logic sd,
                          input logic hd, input logic [1:0] m, input logic b, input logic cp);
    @(negedge clk);
    std_sel = s; line_num = ln; sd_vbi_en = sd; hd_vbi_en = hd;
    timing_mode = m; blank_ctl_en = b; cgms_en = cp; line_start = 1;
    @(negedge clk);
    line_start = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 pass", {15'd0, pass_line}, 16'd1);
    check("R9 ovr", {15'd0, eav_override}, 16'd0);
    rst_n = 1;
    @(negedge clk);
    check("R9 pass after release", {15'd0, pass_line}, 16'd1);

    for (int i = 0; i < NV; i++) begin
      logic [20:0] v;
      v = VEC[i];
      run_line(v[20:19], v[18:8], v[7], v[6], v[5:4], v[3], v[2]);
      check($sformatf("R1-vector%0d pass", i), {15'd0, pass_line}, {15'd0, v[1]});
      check($sformatf("R5 vector%0d ovr", i), {15'd0, eav_override}, {15'd0, v[0]});
      // R7: sample substitution
      check($sformatf("R7 vector%0d pixel", i), {y_out, c_out},
            v[1] ? {y_in, c_in} : 16'h1080);
    end

    // R7: passed line copies new sample values
    run_line(2'd0, 11'd100, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0);
    y_in = 8'hEB; c_in = 8'h10;
    #1;
    check("R7 pass copy", {y_out, c_out}, 16'hEB10);

    // R8: blanked line stays blanked while inputs change mid-line
    run_line(2'd1, 11'd10, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0);
    check("R8 blanked at start", {15'd0, pass_line}, 16'd0);
    sd_vbi_en = 1; line_num = 11'd200; cgms_en = 1;
    repeat (5) @(negedge clk);
    check("R8 held pass", {15'd0, pass_line}, 16'd0);
    check("R8 held ovr", {15'd0, eav_override}, 16'd0);
    check("R7 blank levels", {y_out, c_out}, 16'h1080);
    // next line start picks up the new settings
    run_line(2'd1, 11'd10, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0);
    check("R8 new line pass", {15'd0, pass_line}, 16'd1);
    check("R8 new line ovr", {15'd0, eav_override}, 16'd1);

    // R8: decision not yet applied during the line_start cycle itself
    @(negedge clk);
    std_sel = 2'd1; line_num = 11'd10; sd_vbi_en = 0; timing_mode = 2'd2;
    line_start = 1;
    #1;
    check("R8 old decision in start cycle", {15'd0, pass_line}, 16'd1);
    @(negedge clk);
    line_start = 0;
    check("R8 new decision after edge", {15'd0, pass_line}, 16'd0);

    // R9: asynchronous reset mid-line
    rst_n = 0;
    #1;
    check("R9 async reset pass", {15'd0, pass_line}, 16'd1);
    check("R9 async reset ovr", {15'd0, eav_override}, 16'd0);
    @(negedge clk);
    rst_n = 1;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule